// File: doc/BRIEF.md
# Host Start/Poll Job Mailbox

This block sits between a host-facing register bus and a local memory port, and gives the host a way to launch a job on a memory-side processor and then wait for it to finish. That processor never starts a bus transfer. Every exchange begins with the host. The host writes a job argument to a launch register. The block passes that argument on and raises a start pulse toward the processor. When the processor pulses its done line, the block captures a result word.

The host learns of completion by reading a poll register. If the job is still running, the block does not return a "busy" value. It answers the read with a one-cycle retry indication toward the memory controller. The controller repeats the read until data arrives, so the host only ever sees a stalled read followed by the final result. Every address other than the two registers goes straight through to the memory port, unchanged and never retried.

Top module: `job_mailbox`

## Requirements
- R1: A launch-register write accepted while the block is idle raises `start_o` for exactly the one cycle after the accepting edge. It sets `job_arg_o` to the written data and makes the job running.
- R2: Each poll-register read accepted while a job is running produces `rsp_retry_o` high for one cycle, in the cycle after acceptance, with `rsp_valid_o` low. Reads on back-to-back cycles each get their own retry pulse.
- R3: A launch-register write accepted while a job is running or finished but not yet collected is ignored: no start pulse, and `job_arg_o` is unchanged. It does set a sticky error flag.
- R4: `done_i` while a job is running captures `result_i` and marks the job finished. `done_i` while idle has no effect.
- R5: A poll read accepted while the job is finished returns, in the next cycle, `rsp_valid_o` with data {error flag in bit 31, result in bits 30:0}. The read clears the error flag and returns the block to idle.
- R6: A poll read accepted while idle returns valid data at once, without retry. The data is {0 in bit 31, last captured result in bits 30:0}.
- R7: A read of the launch register returns the current `job_arg_o` value in the next cycle.
- R8: Accesses to any other address are forwarded to the memory port with `req_ready_o` following `mem_ready_i`. Memory read data is returned on the response port, and no retry is ever raised for them.
- R9: After reset, `start_o`, `rsp_valid_o` and `rsp_retry_o` are low, the block is idle, and the poll register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address (launch register 0xFF00, poll register 0xFF04 by default) |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DW | Read data |
| rsp_retry_o | output | 1 | Read must be reissued by the controller |
| mem_valid_o | output | 1 | Forwarded memory request |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_write_o | output | 1 | Forwarded write flag |
| mem_addr_o | output | AW | Forwarded address |
| mem_wdata_o | output | DW | Forwarded write data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DW | Memory read data |
| start_o | output | 1 | Job start pulse to the processor |
| job_arg_o | output | DW | Job argument |
| done_i | input | 1 | Job finished pulse from the processor |
| result_i | input | DW-1 | Job result, captured on `done_i` |

## Verification
On every cycle, the assertions check the state transitions around launch, finish and collection. They also check that the argument holds and the error flag sets on an ignored launch, and that each retry is tied to an accepted poll read in the prior cycle. Only the bench scenarios can show the values the host actually sees: the error bit in the collected word and its clearing on the next read, memory pass-through data, the idle-time `done_i` being dropped, and retry pulses that end after one cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } mbx_state_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] START_ADDR  = 16'hFF00,
  parameter logic [AW-1:0] STATUS_ADDR = 16'hFF04
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic mem_ready_i,
  output logic req_ready_o,
  output logic mem_valid_o,
  output logic start_wr_o,
  output logic start_rd_o,
  output logic status_rd_o
);
  logic hit_start, hit_status, hit_reg, acc;

  assign hit_start   = (req_addr_i == START_ADDR);
  assign hit_status  = (req_addr_i == STATUS_ADDR);
  assign hit_reg     = hit_start | hit_status;
  assign req_ready_o = hit_reg ? 1'b1 : mem_ready_i;
  assign acc         = req_valid_i & req_ready_o;
  assign mem_valid_o = req_valid_i & ~hit_reg;
  assign start_wr_o  = acc & hit_start & req_write_i;
  assign start_rd_o  = acc & hit_start & ~req_write_i;
  assign status_rd_o = acc & hit_status & ~req_write_i;

  // R8
  mem_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !(start_wr_o || start_rd_o || status_rd_o));
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned RW = DW - 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic status_rd_i,
  input  logic done_i,
  input  logic [RW-1:0] result_i,
  output logic start_o,
  output logic [DW-1:0] arg_o,
  output logic busy_o,
  output logic [DW-1:0] status_word_o
);
  mbx_state_e state_q;
  logic [DW-1:0] arg_q;
  logic [RW-1:0] res_q;
  logic err_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      arg_q   <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_wr_i) begin
          arg_q   <= wdata_i;
          start_q <= 1'b1;
          state_q <= ST_BUSY;
        end
        ST_BUSY: begin
          if (start_wr_i) err_q <= 1'b1;
          if (done_i) begin
            res_q   <= result_i;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (start_wr_i) err_q <= 1'b1;
          if (status_rd_i) begin
            err_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o       = start_q;
  assign arg_o         = arg_q;
  assign busy_o        = (state_q == ST_BUSY);
  assign status_word_o = {err_q, res_q};

  // R1
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(start_wr_i) && $past(state_q) == ST_IDLE);
  // R3
  ignored_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_wr_i) |=> $stable(arg_q) && err_q && !start_o);
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && !done_i) |=> state_q == ST_BUSY);
  // R5
  collect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && status_rd_i) |=> state_q == ST_IDLE && !err_q);
endmodule

// File: rtl/mbx_resp.sv
module mbx_resp #(
  parameter int unsigned DW = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_rd_i,
  input  logic status_rd_i,
  input  logic busy_i,
  input  logic [DW-1:0] status_word_i,
  input  logic [DW-1:0] arg_i,
  input  logic mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic rsp_retry_o
);
  logic reg_vld_q, retry_q;
  logic [DW-1:0] reg_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_vld_q  <= 1'b0;
      retry_q    <= 1'b0;
      reg_data_q <= '0;
    end else begin
      reg_vld_q <= start_rd_i | (status_rd_i & ~busy_i);
      retry_q   <= status_rd_i & busy_i;
      if (start_rd_i)       reg_data_q <= arg_i;
      else if (status_rd_i) reg_data_q <= status_word_i;
    end
  end

  // register response wins; host keeps one read outstanding
  assign rsp_valid_o = reg_vld_q | mem_rvalid_i;
  assign rsp_rdata_o = reg_vld_q ? reg_data_q : mem_rdata_i;
  assign rsp_retry_o = retry_q;

  // R2
  retry_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_retry_o |-> $past(status_rd_i) && $past(busy_i));
  // R2
  retry_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && busy_i) |=> rsp_retry_o && !reg_vld_q);
endmodule

// File: rtl/job_mailbox.sv
module job_mailbox #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] START_ADDR  = 16'hFF00,
  parameter logic [AW-1:0] STATUS_ADDR = 16'hFF04
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  output logic req_ready_o,
  input  logic req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic rsp_retry_o,
  output logic mem_valid_o,
  input  logic mem_ready_i,
  output logic mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic start_o,
  output logic [DW-1:0] job_arg_o,
  input  logic done_i,
  input  logic [DW-2:0] result_i
);
  logic start_wr, start_rd, status_rd, busy;
  logic [DW-1:0] status_word;

  mbx_decode #(.AW(AW), .START_ADDR(START_ADDR), .STATUS_ADDR(STATUS_ADDR)) u_dec (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .mem_ready_i,
    .req_ready_o, .mem_valid_o,
    .start_wr_o(start_wr), .start_rd_o(start_rd), .status_rd_o(status_rd)
  );

  mbx_fsm #(.DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .start_wr_i(start_wr), .wdata_i(req_wdata_i), .status_rd_i(status_rd),
    .done_i, .result_i,
    .start_o, .arg_o(job_arg_o), .busy_o(busy), .status_word_o(status_word)
  );

  mbx_resp #(.DW(DW)) u_rsp (
    .clk_i, .rst_ni,
    .start_rd_i(start_rd), .status_rd_i(status_rd), .busy_i(busy),
    .status_word_i(status_word), .arg_i(job_arg_o),
    .mem_rvalid_i, .mem_rdata_i,
    .rsp_valid_o, .rsp_rdata_o, .rsp_retry_o
  );

  assign mem_write_o = req_write_i;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !start_o && !rsp_retry_o);
endmodule

// File: tb/job_mailbox_tb_top.sv
`timescale 1ns/1ps
module job_mailbox_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] SA = 16'hFF00;
  localparam logic [AW-1:0] PA = 16'hFF04;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DN = 2'd2;
  localparam int NV = 14;
  // {op, addr, data, exp_valid, exp_retry, exp_start, exp_value}
  localparam int VW = 2 + AW + DW + 3 + DW;
  localparam logic [VW-1:0] VEC [NV] = '{
    {OP_RD, PA,       32'h0,      1'b1, 1'b0, 1'b0, 32'h0},        // R6
    {OP_WR, SA,       32'h1234,   1'b0, 1'b0, 1'b1, 32'h1234},     // R1
    {OP_RD, PA,       32'h0,      1'b0, 1'b1, 1'b0, 32'h0},        // R2
    {OP_WR, SA,       32'h9999,   1'b0, 1'b0, 1'b0, 32'h1234},     // R3
    {OP_RD, PA,       32'h0,      1'b0, 1'b1, 1'b0, 32'h0},        // R2
    {OP_DN, 16'h0,    32'h55,     1'b0, 1'b0, 1'b0, 32'h1234},     // R4
    {OP_RD, PA,       32'h0,      1'b1, 1'b0, 1'b0, 32'h80000055}, // R5
    {OP_RD, PA,       32'h0,      1'b1, 1'b0, 1'b0, 32'h00000055}, // R6
    {OP_WR, 16'h0010, 32'hCAFE,   1'b0, 1'b0, 1'b0, 32'h1234},     // R8
    {OP_RD, 16'h0010, 32'h0,      1'b1, 1'b0, 1'b0, 32'hCAFE},     // R8
    {OP_RD, SA,       32'h0,      1'b1, 1'b0, 1'b0, 32'h1234},     // R7
    {OP_WR, SA,       32'hAB,     1'b0, 1'b0, 1'b1, 32'hAB},       // R1
    {OP_DN, 16'h0,    32'h7,      1'b0, 1'b0, 1'b0, 32'hAB},       // R4
    {OP_RD, PA,       32'h0,      1'b1, 1'b0, 1'b0, 32'h7}         // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_retry, start;
  logic [DW-1:0] rsp_rdata, job_arg;
  logic mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_rvalid;
  logic [DW-1:0] mem_rdata;
  logic done = 1'b0;
  logic [DW-2:0] result = '0;
  logic [DW-1:0] mem_q [16];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  job_mailbox #(.AW(AW), .DW(DW), .START_ADDR(SA), .STATUS_ADDR(PA)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_retry_o(rsp_retry),
    .mem_valid_o(mem_valid), .mem_ready_i(1'b1), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .start_o(start), .job_arg_o(job_arg), .done_i(done), .result_i(result)
  );

  // simple memory with one-cycle read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_valid & ~mem_write;
      mem_rdata  <= mem_q[mem_addr[5:2]];
      if (mem_valid && mem_write) mem_q[mem_addr[5:2]] <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (op == OP_DN) begin
      done = 1'b1; result = d[DW-2:0];
    end else begin
      req_valid = 1'b1; req_write = (op == OP_WR); req_addr = a; req_wdata = d;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; done = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] op;
    logic [AW-1:0] a;
    logic [DW-1:0] d, ev;
    logic e_v, e_r, e_s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 start", {31'b0, start}, 32'h0);
    chk("R9 valid", {31'b0, rsp_valid}, 32'h0);
    chk("R9 retry", {31'b0, rsp_retry}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      {op, a, d, e_v, e_r, e_s, ev} = VEC[i];
      drive(op, a, d);
      chk($sformatf("vec%0d valid", i), {31'b0, rsp_valid}, {31'b0, e_v});
      chk($sformatf("vec%0d retry R2", i), {31'b0, rsp_retry}, {31'b0, e_r});
      chk($sformatf("vec%0d start R1", i), {31'b0, start}, {31'b0, e_s});
      if (e_v) chk($sformatf("vec%0d rdata", i), rsp_rdata, ev);
      if (op != OP_RD) chk($sformatf("vec%0d arg R3", i), job_arg, ev);
    end

    // R4: done while idle ignored
    drive(OP_DN, '0, 32'h3);
    drive(OP_RD, PA, '0);
    chk("R4 idle done ignored", rsp_rdata, 32'h7);

    // R2: back-to-back polls while running
    drive(OP_WR, SA, 32'h42);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = PA;
    @(posedge clk); @(negedge clk);
    chk("R2 first poll retry", {31'b0, rsp_retry}, 32'h1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R2 second poll retry", {31'b0, rsp_retry}, 32'h1);
    chk("R2 no data on retry", {31'b0, rsp_valid}, 32'h0);
    @(negedge clk);
    chk("R2 retry ends", {31'b0, rsp_retry}, 32'h0);

    // R3: launch while finished sets error
    drive(OP_DN, '0, 32'h11);
    drive(OP_WR, SA, 32'h77);
    chk("R3 no start when done", {31'b0, start}, 32'h0);
    chk("R3 arg kept", job_arg, 32'h42);
    drive(OP_RD, PA, '0);
    chk("R3 error bit", rsp_rdata, 32'h80000011);

    // R9: reset mid-job
    drive(OP_WR, SA, 32'h5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(OP_RD, PA, '0);
    chk("R9 no retry after reset", {31'b0, rsp_retry}, 32'h0);
    chk("R9 poll reads zero", rsp_rdata, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule